// File: doc/BRIEF.md
# Cross-Product Arctangent FM Discriminator

The block recovers the message from a frequency-modulated signal that has already been mixed down to complex baseband. Each accepted I/Q sample is paired with the sample accepted before it. Two terms are formed from the pair. The cross product gives the sine of the phase advance between the two samples, and the dot product gives its cosine. A sequential CORDIC in vectoring mode turns the two terms into the phase advance, so the design needs neither a divider nor a large arctangent table.

The phase advance is proportional to the instantaneous frequency deviation. It is multiplied by a fixed gain ratio to reach message amplitude. A 16-sample moving average then removes residual ripple.

Samples enter with a one-cycle valid strobe. The `busy` output tells the source when a new sample will be taken. Each accepted sample yields exactly one output strobe with one demodulated value.

Top module: `fm_xprod_discrim`

## Requirements
- R1: A sample is accepted on a rising edge where `in_valid` is 1 and `busy` is 0. The sine term is Q·Iprev − I·Qprev and the cosine term is I·Iprev + Q·Qprev, where "prev" is the previously accepted sample. After reset the previous sample is (0,0), so the first output after reset is 0.
- R2: Angles are coded as signed ANG_W-bit values with 2^(ANG_W-1) standing for π. For a positive cosine term, the angle is atan(sine/cosine) within the residual error of ITERS iterations.
- R3: When the cosine term is exactly zero, the angle is +2^(ANG_W-2) for a positive sine term and −2^(ANG_W-2) for a negative one. When both terms are zero, the angle is 0.
- R4: When the cosine term is negative, both terms are negated before vectoring. The result is the true phase advance folded by ∓π into [−π/2, +π/2] (a step of 20000 codes yields −12768).
- R5: The angle is scaled as (angle·GAIN) >>> GAIN_SHIFT, arithmetic shift. The output is the sum of the last 16 scaled values shifted right arithmetically by 4. The history resets to zeros. With the defaults GAIN=3 and GAIN_SHIFT=1, the first nonzero value after a zero history is (1.5·angle)/16.
- R6: `out_valid` rises exactly ITERS+3 rising edges after the accepting edge and lasts one cycle. `out_data` holds the value from then on.
- R7: `busy` is 1 from the cycle after acceptance for ITERS+1 cycles. A strobe while `busy` is 1 produces no output and does not replace the previous sample.
- R8: After reset, `out_valid`, `busy` and `out_data` are all 0.
- R9: Every angle leaving the CORDIC lies within ±2^(ANG_W-2). Results that overshoot in the last iteration are clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | IQ_W | In-phase sample, signed |
| in_q | input | IQ_W | Quadrature sample, signed |
| busy | output | 1 | High while a sample is being resolved; strobes are ignored |
| out_valid | output | 1 | One-cycle strobe for a new output |
| out_data | output | OUT_W | Demodulated, averaged value, signed |

## Verification
The assertions check on every cycle the properties that need no knowledge of the input signal:
- the angle range;
- the non-negative x register during vectoring;
- the fixed two-cycle path from angle to output;
- the single-cycle output strobe;
- `busy` rising on acceptance and falling only as an angle is produced;
- the previous sample holding while `busy` is high.

Only the bench scenarios can show the numerical results: the arctangent accuracy for several constant phase steps, the exact quarter-turn codes at a zero cosine, the folding of steps beyond a quarter turn, the moving-average ramp, and the discarding of a strobe that arrives mid-iteration.

// File: rtl/fmd_pkg.sv
package fmd_pkg;

  // Sine of the phase advance: cross product of current and previous sample
  function automatic longint cross_term(input longint cur_i, input longint cur_q,
                                        input longint prv_i, input longint prv_q);
    return cur_q * prv_i - cur_i * prv_q;
  endfunction

  // Cosine of the phase advance: dot product of current and previous sample
  function automatic longint dot_term(input longint cur_i, input longint cur_q,
                                      input longint prv_i, input longint prv_q);
    return cur_i * prv_i + cur_q * prv_q;
  endfunction

  // Elementary rotation angle atan(2^-idx), coded with 2^(ang_w-1) = pi.
  // Held at a 24-bit scale (2^23 = pi) and rounded down to ang_w (ang_w <= 23).
  function automatic int atan_code(input int idx, input int ang_w);
    int v;
    case (idx)
      0:  v = 2097152;
      1:  v = 1238021;
      2:  v = 654136;
      3:  v = 332050;
      4:  v = 166669;
      5:  v = 83416;
      6:  v = 41718;
      7:  v = 20860;
      8:  v = 10430;
      9:  v = 5215;
      10: v = 2608;
      11: v = 1304;
      12: v = 652;
      13: v = 326;
      14: v = 163;
      15: v = 81;
      default: v = 0;
    endcase
    return (v + (1 << (23 - ang_w))) >>> (24 - ang_w);
  endfunction

  // Code of +pi/2
  function automatic int quarter_code(input int ang_w);
    return 1 << (ang_w - 2);
  endfunction

  // Gain stage: multiply, then arithmetic right shift
  function automatic longint scale_code(input longint a, input int gain, input int shift);
    return (a * longint'(gain)) >>> shift;
  endfunction

endpackage

// File: rtl/fmd_phase_terms.sv
module fmd_phase_terms #(
  parameter int IQ_W   = 12,
  parameter int TERM_W = 2 * IQ_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic signed [IQ_W-1:0]   in_i,
  input  logic signed [IQ_W-1:0]   in_q,
  output logic                     term_vld,
  output logic signed [TERM_W-1:0] sin_t,
  output logic signed [TERM_W-1:0] cos_t,
  output logic signed [IQ_W-1:0]   prev_i,
  output logic signed [IQ_W-1:0]   prev_q
);
  import fmd_pkg::*;

  logic signed [TERM_W-1:0] sin_n, cos_n;

  always_comb begin
    sin_n = TERM_W'(cross_term(longint'(in_i), longint'(in_q),
                               longint'(prev_i), longint'(prev_q)));
    cos_n = TERM_W'(dot_term(longint'(in_i), longint'(in_q),
                             longint'(prev_i), longint'(prev_q)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_vld <= 1'b0;
      sin_t    <= '0;
      cos_t    <= '0;
      prev_i   <= '0;
      prev_q   <= '0;
    end else begin
      term_vld <= accept;
      if (accept) begin
        sin_t  <= sin_n;
        cos_t  <= cos_n;
        prev_i <= in_i;
        prev_q <= in_q;
      end
    end
  end

endmodule

// File: rtl/fmd_cordic_vec.sv
module fmd_cordic_vec #(
  parameter int TERM_W = 25,
  parameter int ANG_W  = 16,
  parameter int ITERS  = 8,
  parameter int CW     = TERM_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic signed [TERM_W-1:0] sin_t,
  input  logic signed [TERM_W-1:0] cos_t,
  output logic                     run,
  output logic                     ang_vld,
  output logic signed [ANG_W-1:0]  ang,
  output logic signed [CW-1:0]     x_mon
);
  import fmd_pkg::*;

  localparam int ZW = ANG_W + 1;
  localparam int IW = $clog2(ITERS + 1);
  localparam logic [IW-1:0] LAST = IW'(ITERS - 1);
  localparam logic signed [ZW-1:0] QZ = ZW'(quarter_code(ANG_W));

  logic signed [CW-1:0]    x_r, y_r, xs, ys, x_n, y_n;
  logic signed [ZW-1:0]    z_r, z_n, a_i;
  logic [IW-1:0]           iter;
  logic                    guard;
  logic signed [ANG_W-1:0] gval, ang_fin;
  logic                    rot_down;
  logic                    cos_neg;
  logic signed [CW-1:0]    x_ld, y_ld;

  // Operand conditioning: keep x non-negative so the result stays in +-pi/2
  always_comb begin
    cos_neg = cos_t[TERM_W-1];
    x_ld    = cos_neg ? -CW'(cos_t) : CW'(cos_t);
    y_ld    = cos_neg ? -CW'(sin_t) : CW'(sin_t);
  end

  // One micro-rotation: barrel shifts, add/subtract, angle ROM
  always_comb begin
    xs       = x_r >>> iter;
    ys       = y_r >>> iter;
    a_i      = ZW'(atan_code(int'(iter), ANG_W));
    rot_down = ~y_r[CW-1];
    x_n      = rot_down ? x_r + ys : x_r - ys;
    y_n      = rot_down ? y_r - xs : y_r + xs;
    z_n      = rot_down ? z_r + a_i : z_r - a_i;
  end

  // Clamp the residual overshoot of the final iteration
  always_comb begin
    if (z_n > QZ)       ang_fin = ANG_W'(QZ);
    else if (z_n < -QZ) ang_fin = ANG_W'(-QZ);
    else                ang_fin = ANG_W'(z_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_r     <= '0;
      y_r     <= '0;
      z_r     <= '0;
      iter    <= '0;
      run     <= 1'b0;
      guard   <= 1'b0;
      gval    <= '0;
      ang_vld <= 1'b0;
      ang     <= '0;
    end else begin
      ang_vld <= 1'b0;
      if (start) begin
        x_r   <= x_ld;
        y_r   <= y_ld;
        z_r   <= '0;
        iter  <= '0;
        run   <= 1'b1;
        guard <= (cos_t == '0);
        if (sin_t == '0)          gval <= '0;
        else if (sin_t[TERM_W-1]) gval <= ANG_W'(-QZ);
        else                      gval <= ANG_W'(QZ);
      end else if (run) begin
        x_r  <= x_n;
        y_r  <= y_n;
        z_r  <= z_n;
        iter <= iter + 1'b1;
        if (iter == LAST) begin
          run     <= 1'b0;
          ang_vld <= 1'b1;
          ang     <= guard ? gval : ang_fin;
        end
      end
    end
  end

  assign x_mon = x_r;

endmodule

// File: rtl/fmd_post.sv
module fmd_post #(
  parameter int ANG_W      = 16,
  parameter int OUT_W      = 18,
  parameter int GAIN       = 3,
  parameter int GAIN_SHIFT = 1,
  parameter int TAPS       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ang_vld,
  input  logic signed [ANG_W-1:0] ang,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  import fmd_pkg::*;

  localparam int SH = $clog2(TAPS);
  localparam int SW = OUT_W + SH;

  logic signed [OUT_W-1:0] scaled;
  logic                    sc_vld;
  logic signed [OUT_W-1:0] sc_val;
  logic signed [OUT_W-1:0] hist [TAPS];
  logic signed [SW-1:0]    sum_r, sum_n;

  // Gain variant chosen by parameters
  generate
    if (GAIN == 1 && GAIN_SHIFT == 0) begin : g_unity
      assign scaled = OUT_W'(ang);
    end else begin : g_mult
      assign scaled = OUT_W'(scale_code(longint'(ang), GAIN, GAIN_SHIFT));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_vld <= 1'b0;
      sc_val <= '0;
    end else begin
      sc_vld <= ang_vld;
      if (ang_vld) sc_val <= scaled;
    end
  end

  // Running sum: newest in, oldest out
  assign sum_n = sum_r + SW'(sc_val) - SW'(hist[TAPS-1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) hist[k] <= '0;
      sum_r     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= sc_vld;
      if (sc_vld) begin
        hist[0] <= sc_val;
        for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
        sum_r    <= sum_n;
        out_data <= OUT_W'(sum_n >>> SH);
      end
    end
  end

endmodule

// File: rtl/fm_xprod_discrim.sv
module fm_xprod_discrim #(
  parameter int IQ_W       = 12,
  parameter int ANG_W      = 16,
  parameter int ITERS      = 8,
  parameter int OUT_W      = 18,
  parameter int GAIN       = 3,
  parameter int GAIN_SHIFT = 1,
  parameter int TAPS       = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IQ_W-1:0]  in_i,
  input  logic signed [IQ_W-1:0]  in_q,
  output logic                    busy,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int TERM_W   = 2 * IQ_W + 1;
  localparam int CORDIC_W = TERM_W + 2;

  logic                      accept;
  logic                      term_vld;
  logic signed [TERM_W-1:0]  sin_t, cos_t;
  logic signed [IQ_W-1:0]    prev_i, prev_q;
  logic                      run;
  logic                      ang_vld;
  logic signed [ANG_W-1:0]   ang;
  logic signed [CORDIC_W-1:0] x_mon;

  assign busy   = term_vld | run;
  assign accept = in_valid & ~busy;

  fmd_phase_terms #(.IQ_W(IQ_W), .TERM_W(TERM_W)) u_terms (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_i(in_i), .in_q(in_q),
    .term_vld(term_vld), .sin_t(sin_t), .cos_t(cos_t),
    .prev_i(prev_i), .prev_q(prev_q)
  );

  fmd_cordic_vec #(.TERM_W(TERM_W), .ANG_W(ANG_W), .ITERS(ITERS), .CW(CORDIC_W)) u_cordic (
    .clk(clk), .rst_n(rst_n), .start(term_vld), .sin_t(sin_t), .cos_t(cos_t),
    .run(run), .ang_vld(ang_vld), .ang(ang), .x_mon(x_mon)
  );

  fmd_post #(.ANG_W(ANG_W), .OUT_W(OUT_W), .GAIN(GAIN),
             .GAIN_SHIFT(GAIN_SHIFT), .TAPS(TAPS)) u_post (
    .clk(clk), .rst_n(rst_n), .ang_vld(ang_vld), .ang(ang),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/fmd_checker.sv
module fmd_checker #(
  parameter int IQ_W  = 12,
  parameter int ANG_W = 16,
  parameter int CW    = 27
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    busy,
  input logic signed [IQ_W-1:0]  prev_i,
  input logic signed [IQ_W-1:0]  prev_q,
  input logic                    run,
  input logic signed [CW-1:0]    x_mon,
  input logic                    ang_vld,
  input logic signed [ANG_W-1:0] ang,
  input logic                    out_valid
);
  localparam logic signed [ANG_W-1:0] QA = ANG_W'(1 << (ANG_W - 2));

  assert_angle_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ang_vld |-> (ang <= QA && ang >= -QA));

  assert_x_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> !x_mon[CW-1]);

  assert_out_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ang_vld |=> ##1 out_valid);

  assert_out_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> busy);

  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ang_vld);

  assert_prev_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(prev_i) && $stable(prev_q)));

endmodule

bind fm_xprod_discrim fmd_checker #(.IQ_W(IQ_W), .ANG_W(ANG_W), .CW(CORDIC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .busy(busy),
  .prev_i(prev_i), .prev_q(prev_q), .run(run), .x_mon(x_mon),
  .ang_vld(ang_vld), .ang(ang), .out_valid(out_valid)
);

// File: tb/fm_xprod_discrim_tb.sv
`timescale 1ns/1ps
module fm_xprod_discrim_tb;

  localparam int AMP = 1500;
  localparam int NROW = 8;
  // Phase step per sample (pi = 32768), expected settled output, tolerance
  localparam int STEP_TAB [NROW] = '{0, 2000, -3500, 8192, -11000, 16384, -16384, 20000};
  localparam int EXP_TAB  [NROW] = '{0, 3000, -5250, 12288, -16500, 24576, -24576, -19152};
  localparam int TOL_TAB  [NROW] = '{160, 160, 160, 160, 160, 0, 0, 160};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0;
  logic busy, out_valid;
  logic signed [17:0] out_data;

  int errors = 0;
  int checks = 0;
  int n_out = 0;

  always #10 clk = ~clk;

  fm_xprod_discrim u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );

  always @(negedge clk) if (out_valid) n_out++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(0.5 - r);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_out = 0;
  endtask

  // Drive one sample; optionally strobe a junk sample while busy.
  task automatic push(input int si, input int sq, input bit junk,
                      output int o, output int lat, output int nbusy);
    @(negedge clk);
    while (busy) @(negedge clk);
    in_i = 12'(si); in_q = 12'(sq); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin in_i = 12'(777); in_q = -12'sd555; in_valid = 1'b1; end
    else in_valid = 1'b0;
    lat = 0; nbusy = busy ? 1 : 0;
    while (lat < 60) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      in_valid = 1'b0;
      if (busy) nbusy++;
      if (out_valid) break;
    end
    o = int'(out_data);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int o, lat, nb;
    do_reset();
    // R8: reset state
    check(out_valid == 1'b0 && busy == 1'b0 && out_data == '0, "R8 reset state",
          int'(out_data) + (busy ? 1000 : 0) + (out_valid ? 2000 : 0), 0);

    // Table walk: constant phase step per row
    for (int r = 0; r < NROW; r++) begin
      do_reset();
      for (int k = 0; k < 17; k++) begin
        real ph;
        ph = real'(k) * real'(STEP_TAB[r]) * 3.14159265358979 / 32768.0;
        push(rnd(AMP * $cos(ph)), rnd(AMP * $sin(ph)), (r == 3) && (k % 2 == 1), o, lat, nb);
        if (k == 0) begin
          check(o == 0, "R1 first output after reset", o, 0);
          if (r == 0) begin
            check(lat == 11, "R6 latency", lat, 11);
            check(nb == 9, "R7 busy length", nb, 9);
          end
        end
        if (k == 1 && r == 3)
          check(o >= 752 && o <= 784, "R5 average ramp", o, 768);
        if (k == 1 && r == 5)
          check(o == 1536, "R5 average ramp exact", o, 1536);
      end
      repeat (20) @(negedge clk);
      check(n_out == 17, (r == 3) ? "R7 busy strobes ignored" : "R6 one output per sample",
            n_out, 17);
      if (STEP_TAB[r] == 16384 || STEP_TAB[r] == -16384)
        check(o == EXP_TAB[r], "R3 zero cosine quarter turn", o, EXP_TAB[r]);
      else if (STEP_TAB[r] > 16384)
        check(o >= EXP_TAB[r] - TOL_TAB[r] && o <= EXP_TAB[r] + TOL_TAB[r],
              "R4 negative cosine fold", o, EXP_TAB[r]);
      else
        check(o >= EXP_TAB[r] - TOL_TAB[r] && o <= EXP_TAB[r] + TOL_TAB[r],
              (r == 3) ? "R7 R2 step after ignored strobes" : "R2 arctangent step",
              o, EXP_TAB[r]);
    end

    // Directed: both terms zero, then a quarter turn from a zero history
    do_reset();
    push(0, 0, 1'b0, o, lat, nb);
    check(o == 0, "R3 both terms zero", o, 0);
    push(0, 0, 1'b0, o, lat, nb);
    check(o == 0, "R3 both terms zero again", o, 0);
    push(AMP, 0, 1'b0, o, lat, nb);
    check(o == 0, "R1 previous sample zero", o, 0);
    push(0, AMP, 1'b0, o, lat, nb);
    check(o == 1536, "R3 positive quarter after zeros", o, 1536);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule